// File: doc/BRIEF.md
# Key-Locked Flash Program Guard

This block sits between a register bus and a small on-chip flash model. Every change to the array has to pass its rules. After reset the guard is locked. Software opens it by writing two secret 32-bit words, in order, to a key register. Any wrong key makes the lock permanent until the next reset. While the guard is open and program-enable is set, a write through the array port clears bits in the addressed word and never sets them. Byte enables choose which bytes take part. A page-erase command returns every word of one page to all ones.

Illegal array writes leave the array unchanged and are recorded in sticky error flags. The flags appear a fixed number of cycles after the offending write. While any flag is set, all programming and erasing is refused. Software clears a flag by writing 1 to it. An optional half-word mode rejects array writes that are not exactly 16 bits wide and signals a bus fault instead.

The key sequence is a four-state machine. The states are LOCKED, HALF (first key seen), OPEN and DEAD. The transitions are:
- LOCKED to HALF on a write of the first key.
- HALF to OPEN on a write of the second key.
- LOCKED or HALF to DEAD on any other key value.
- OPEN to DEAD on any key write.
- OPEN to LOCKED on a relock command.
- DEAD holds until reset.

Top module: `flash_guard`

Register map on `reg_addr`:
- 0 is the key register. It is write-only and reads as 0.
- 1 is the control register:
  - bit0 program-enable
  - bit1 interrupt-enable
  - bit2 half-word mode
  - bit3 relock (write-only)
  - bit4 erase-go (write-only)
  - bits[10:8] page index
- 2 is the status register:
  - bit0 program error
  - bit1 sequence error
  - bit4 locked
  - bit5 dead

## Requirements
- R1: After reset the guard is locked (status reads 0x10), the control register reads 0, every array word reads 0xFFFFFFFF, and `bus_fault` and `irq` are low.
- R2: A write of 0x5A17C3E0 to register 0 followed by a write of 0xA5E83C1F opens the guard, so status bit4 reads 0. After the first key alone, status still reads 0x10.
- R3: In LOCKED or HALF, a key write of any other value, and in OPEN, any key write at all, enters DEAD (status 0x30). Later correct keys leave it DEAD until reset.
- R4: While the guard is not OPEN, writes to the control register change none of its fields, and reading it back shows the old value.
- R5: An array write while locked leaves the word unchanged and sets both status bit0 and bit1. An array write while OPEN with program-enable clear leaves the word unchanged and sets bit1 only.
- R6: The error flags from a rejected write are still clear one cycle after that write's clock edge. They read as set two cycles after it.
- R7: An accepted write stores old AND new in each byte whose enable is set, and keeps the other bytes. No bit ever goes from 0 to 1 by programming.
- R8: While any error flag is set, array writes and erase commands have no effect, even when the guard is OPEN. Writing 1 to a flag clears it, and programming then works again.
- R9: In half-word mode, an array write whose byte enables are nonzero and are neither 0011 nor 1100 programs nothing and sets no error. It drives `bus_fault` high for exactly the cycle after the write. A write with enables 0011 or 1100 programs normally.
- R10: Writing control bit3 while OPEN returns the guard to LOCKED and clears program-enable. The full two-key sequence opens it again.
- R11: While OPEN and with no error flags set, a control write with bit4 set and page p in bits[10:8] sets words 8p to 8p+7 to 0xFFFFFFFF and leaves other pages unchanged. While locked, the same write does nothing.
- R12: `irq` is high exactly when interrupt-enable is set and at least one error flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_wr | input | 1 | Array write strobe |
| mem_addr | input | 6 | Array word address for writes and reads |
| mem_be | input | 4 | Byte enables of the array write |
| mem_wdata | input | 32 | Array write data |
| mem_rdata | output | 32 | Array word at `mem_addr` (combinational) |
| bus_fault | output | 1 | One-cycle pulse after a write of illegal width in half-word mode |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume the following about the inputs:
- A register write and an array write stay in the same cycle, and the stimulus never overlaps a page erase with a program to a word of that page.
- `mem_addr` may change freely. For that reason, the checks that an array word is frozen only apply when the address is held across two cycles.

The directed tasks drive one strobe per cycle on the falling edge. They keep the address steady around each rejected write, so that both assertions and bench checks observe the same word.

// File: rtl/flg_pkg.sv
`timescale 1ns/1ps
package flg_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2,
        KS_DEAD   = 2'd3
    } key_state_e;

    localparam logic [1:0] RA_KEY  = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;

    localparam int CB_PROG   = 0;
    localparam int CB_IRQ    = 1;
    localparam int CB_HALF   = 2;
    localparam int CB_RELOCK = 3;
    localparam int CB_ERASE  = 4;
    localparam int CB_PAGE   = 8;

    localparam int SB_PROG   = 0;
    localparam int SB_SEQ    = 1;
    localparam int SB_LOCKED = 4;
    localparam int SB_DEAD   = 5;

    localparam int ERR_BITS  = 2;
endpackage

// File: rtl/flg_key_fsm.sv
`timescale 1ns/1ps
module flg_key_fsm import flg_pkg::*; #(
    parameter int              KEY_W      = 32,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 32'h5A17_C3E0,
    parameter logic [KEY_W-1:0] KEY_SECOND = 32'hA5E8_3C1F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             relock,
    output logic             unlocked,
    output logic             dead
);
    key_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KS_LOCKED: if (key_wr) st_d = (key_val == KEY_FIRST)  ? KS_HALF : KS_DEAD;
            KS_HALF:   if (key_wr) st_d = (key_val == KEY_SECOND) ? KS_OPEN : KS_DEAD;
            KS_OPEN: begin
                if (key_wr)      st_d = KS_DEAD;
                else if (relock) st_d = KS_LOCKED;
            end
            KS_DEAD:   st_d = KS_DEAD;
            default:   st_d = KS_DEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        unlocked = (st_q == KS_OPEN);
        dead     = (st_q == KS_DEAD);
    end

    AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> dead);  // R3
    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_wr));  // R2
endmodule

// File: rtl/flg_err_track.sv
`timescale 1ns/1ps
module flg_err_track #(
    parameter int LAT = 2,
    parameter int NB  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_req,
    input  logic          clr_wr,
    input  logic [NB-1:0] clr_mask,
    output logic [NB-1:0] err_q
);
    logic [LAT-1:0][NB-1:0] pipe_q;
    logic [NB-1:0]          clr_eff;

    always_comb clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            err_q  <= '0;
        end else begin
            pipe_q[0] <= set_req;
            for (int s = 1; s < LAT; s++) pipe_q[s] <= pipe_q[s-1];
            err_q <= (err_q & ~clr_eff) | pipe_q[LAT-1];
        end
    end
endmodule

// File: rtl/flg_array.sv
`timescale 1ns/1ps
module flg_array #(
    parameter int WORDS      = 64,
    parameter int PAGE_WORDS = 8,
    parameter int DATA_W     = 32,
    localparam int AW    = $clog2(WORDS),
    localparam int PAGES = WORDS / PAGE_WORDS,
    localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int PO    = $clog2(PAGE_WORDS),
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic [AW-1:0]     addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              erase,
    input  logic [PW-1:0]     page,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] keep_mask;

    generate
        for (genvar b = 0; b < BE_W; b++) begin : g_mask
            assign keep_mask[b*8 +: 8] = {8{~be[b]}};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (erase && (PW'(i / PAGE_WORDS) == page))
                    mem[i] <= '1;
                else if (prog && (addr == AW'(i)))
                    mem[i] <= mem[i] & (wdata | keep_mask);
            end
        end
    end

    assign rd_data = mem[addr];

    AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (prog && !erase) |=> ((mem[$past(addr)] & ~$past(mem[addr])) == '0));  // R7
    AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[{$past(page), {PO{1'b0}}}] == '1));  // R11
endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard import flg_pkg::*; #(
    parameter int          WORDS      = 64,
    parameter int          PAGE_WORDS = 8,
    parameter int          ERR_LAT    = 2,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] KEY_FIRST  = 32'h5A17_C3E0,
    parameter logic [31:0] KEY_SECOND = 32'hA5E8_3C1F
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [1:0]                 reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic                       mem_wr,
    input  logic [$clog2(WORDS)-1:0]   mem_addr,
    input  logic [DATA_W/8-1:0]        mem_be,
    input  logic [DATA_W-1:0]          mem_wdata,
    output logic [DATA_W-1:0]          mem_rdata,
    output logic                       bus_fault,
    output logic                       irq
);
    localparam int BE_W  = DATA_W / 8;
    localparam int PAGES = WORDS / PAGE_WORDS;
    localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam logic [BE_W-1:0] BE_LO = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    localparam logic [BE_W-1:0] BE_HI = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

    logic unlocked, dead;
    logic key_wr, ctrl_wr, stat_wr;
    logic relock_req, erase_req, arr_prog;
    logic prog_en_q, irq_en_q, half_q, fault_q;
    logic size_bad, err_any;
    logic [ERR_BITS-1:0] err_set, err_q;
    logic unused_wdata;

    always_comb begin
        key_wr     = reg_wr && (reg_addr == RA_KEY);
        ctrl_wr    = reg_wr && (reg_addr == RA_CTRL);
        stat_wr    = reg_wr && (reg_addr == RA_STAT);
        err_any    = |err_q;
        relock_req = ctrl_wr && unlocked && reg_wdata[CB_RELOCK];
        erase_req  = ctrl_wr && unlocked && !reg_wdata[CB_RELOCK]
                     && reg_wdata[CB_ERASE] && !err_any;
        size_bad   = half_q && (mem_be != '0) && (mem_be != BE_LO) && (mem_be != BE_HI);
        arr_prog   = mem_wr && !size_bad && unlocked && prog_en_q && !err_any;
        err_set    = '0;
        if (mem_wr && !size_bad) begin
            if (!unlocked) begin
                err_set[SB_PROG] = 1'b1;
                err_set[SB_SEQ]  = 1'b1;
            end else if (!prog_en_q) begin
                err_set[SB_SEQ]  = 1'b1;
            end
        end
    end

    assign unused_wdata = ^reg_wdata;

    flg_key_fsm #(
        .KEY_W      (32),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (reg_wdata[31:0]),
        .relock   (relock_req),
        .unlocked (unlocked),
        .dead     (dead)
    );

    flg_err_track #(
        .LAT (ERR_LAT),
        .NB  (ERR_BITS)
    ) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (err_set),
        .clr_wr   (stat_wr),
        .clr_mask (reg_wdata[ERR_BITS-1:0]),
        .err_q    (err_q)
    );

    flg_array #(
        .WORDS      (WORDS),
        .PAGE_WORDS (PAGE_WORDS),
        .DATA_W     (DATA_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog    (arr_prog),
        .addr    (mem_addr),
        .be      (mem_be),
        .wdata   (mem_wdata),
        .erase   (erase_req),
        .page    (reg_wdata[CB_PAGE +: PW]),
        .rd_data (mem_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_en_q <= 1'b0;
            irq_en_q  <= 1'b0;
            half_q    <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            fault_q <= mem_wr && size_bad;
            if (relock_req) begin
                prog_en_q <= 1'b0;
            end else if (ctrl_wr && unlocked) begin
                prog_en_q <= reg_wdata[CB_PROG];
                irq_en_q  <= reg_wdata[CB_IRQ];
                half_q    <= reg_wdata[CB_HALF];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_PROG] = prog_en_q;
                reg_rdata[CB_IRQ]  = irq_en_q;
                reg_rdata[CB_HALF] = half_q;
            end
            RA_STAT: begin
                reg_rdata[SB_PROG]   = err_q[SB_PROG];
                reg_rdata[SB_SEQ]    = err_q[SB_SEQ];
                reg_rdata[SB_LOCKED] = !unlocked;
                reg_rdata[SB_DEAD]   = dead;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign bus_fault = fault_q;
    assign irq       = irq_en_q && err_any;

    AST_FAULT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |-> $past(mem_wr));  // R9
    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && $past(!unlocked)) |-> ($stable(irq_en_q) && $stable(half_q)));  // R4
    AST_LOCKED_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && mem_wr) |=> ((mem_addr != $past(mem_addr)) || $stable(mem_rdata)));  // R5
    AST_ERR_FREEZES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && mem_wr) |=> ((mem_addr != $past(mem_addr)) || $stable(mem_rdata)));  // R8
endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
    localparam logic [31:0] K1 = 32'h5A17_C3E0;
    localparam logic [31:0] K2 = 32'hA5E8_3C1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_wr = 1'b0;
    logic [5:0]  mem_addr = '0;
    logic [3:0]  mem_be = '0;
    logic [31:0] mem_wdata = '0;
    logic [31:0] mem_rdata;
    logic        bus_fault, irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    flash_guard u_flash_guard (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .bus_fault(bus_fault), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 0; mem_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rrd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic mwr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_be = be; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic mrd(input logic [5:0] a, output logic [31:0] d);
        mem_addr = a; #1; d = mem_rdata;
    endtask

    task automatic unlock();
        rwr(2'd0, K1);
        rwr(2'd0, K2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rrd(2'd2, v); chk("R1", "status", v, 32'h10);
        rrd(2'd1, v); chk("R1", "ctrl", v, 32'h0);
        mrd(6'd0, v);  chk("R1", "word0", v, 32'hFFFF_FFFF);
        mrd(6'd63, v); chk("R1", "word63", v, 32'hFFFF_FFFF);
        chk("R1", "bus_fault", {31'd0, bus_fault}, 32'd0);
        chk("R1", "irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_unlock();
        logic [31:0] v;
        do_reset();
        rwr(2'd0, K1);
        rrd(2'd2, v); chk("R2", "status after first key", v, 32'h10);
        rwr(2'd0, K2);
        rrd(2'd2, v); chk("R2", "status open", v, 32'h0);
    endtask

    task automatic t_wrong_key();
        logic [31:0] v;
        do_reset();
        rwr(2'd0, K1);
        rwr(2'd0, 32'h0BAD_0BAD);
        rrd(2'd2, v); chk("R3", "dead after bad second key", v, 32'h30);
        unlock();
        rrd(2'd2, v); chk("R3", "still dead after good keys", v, 32'h30);
        do_reset();
        unlock();
        rwr(2'd0, K1);
        rrd(2'd2, v); chk("R3", "dead on key write while open", v, 32'h30);
    endtask

    task automatic t_ctrl_locked();
        logic [31:0] v;
        do_reset();
        rwr(2'd1, 32'h7);
        rrd(2'd1, v); chk("R4", "ctrl ignored when locked", v, 32'h0);
        unlock();
        rwr(2'd1, 32'h6);
        rrd(2'd1, v); chk("R4", "ctrl written when open", v, 32'h6);
    endtask

    task automatic t_locked_write();
        logic [31:0] v;
        do_reset();
        mwr(6'd5, 4'hF, 32'h0);
        rrd(2'd2, v); chk("R6", "no error at write edge", v, 32'h10);
        mrd(6'd5, v); chk("R5", "locked word unchanged", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rrd(2'd2, v); chk("R6", "no error one cycle later", v, 32'h10);
        @(negedge clk);
        rrd(2'd2, v); chk("R5", "both errors set", v, 32'h13);
        do_reset();
        unlock();
        mwr(6'd6, 4'hF, 32'h0);
        repeat (2) @(negedge clk);
        rrd(2'd2, v); chk("R5", "sequence error only", v, 32'h02);
        mrd(6'd6, v); chk("R5", "word unchanged prog disabled", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_and_program();
        logic [31:0] v;
        do_reset();
        unlock();
        rwr(2'd1, 32'h1);
        mwr(6'd10, 4'hF, 32'hF0F0_3C3C);
        mrd(6'd10, v); chk("R7", "first program", v, 32'hF0F0_3C3C);
        mwr(6'd10, 4'hF, 32'hFF00_FF00);
        mrd(6'd10, v); chk("R7", "AND of old and new", v, 32'hF000_3C00);
        mwr(6'd10, 4'b0010, 32'h0);
        mrd(6'd10, v); chk("R7", "byte enable one byte", v, 32'hF000_0000);
        mwr(6'd10, 4'hF, 32'hFFFF_FFFF);
        mrd(6'd10, v); chk("R7", "ones cannot be set", v, 32'hF000_0000);
        mrd(6'd11, v); chk("R7", "neighbour untouched", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_err_block();
        logic [31:0] v;
        do_reset();
        unlock();
        rwr(2'd1, 32'h1);
        mwr(6'd21, 4'hF, 32'h1234_5678);
        rwr(2'd1, 32'h0);
        mwr(6'd20, 4'hF, 32'h0);
        repeat (2) @(negedge clk);
        rrd(2'd2, v); chk("R8", "error present", v, 32'h02);
        rwr(2'd1, 32'h1);
        mwr(6'd20, 4'hF, 32'h0);
        mrd(6'd20, v); chk("R8", "program blocked", v, 32'hFFFF_FFFF);
        rwr(2'd1, (32'd2 << 8) | 32'h11);
        mrd(6'd21, v); chk("R8", "erase blocked", v, 32'h1234_5678);
        rwr(2'd2, 32'h2);
        rrd(2'd2, v); chk("R8", "write one clears", v, 32'h0);
        mwr(6'd20, 4'hF, 32'h0);
        mrd(6'd20, v); chk("R8", "program after clear", v, 32'h0);
    endtask

    task automatic t_half_mode();
        logic [31:0] v;
        do_reset();
        unlock();
        rwr(2'd1, 32'h5);
        mwr(6'd30, 4'hF, 32'h0);
        chk("R9", "fault on 32-bit write", {31'd0, bus_fault}, 32'd1);
        mrd(6'd30, v); chk("R9", "no program on fault", v, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R9", "fault lasts one cycle", {31'd0, bus_fault}, 32'd0);
        @(negedge clk);
        rrd(2'd2, v); chk("R9", "no error from fault", v, 32'h0);
        mwr(6'd30, 4'b0011, 32'h0);
        chk("R9", "no fault low half", {31'd0, bus_fault}, 32'd0);
        mrd(6'd30, v); chk("R9", "low half programmed", v, 32'hFFFF_0000);
        mwr(6'd30, 4'b1100, 32'h0000_FFFF);
        mrd(6'd30, v); chk("R9", "high half programmed", v, 32'h0000_0000);
        mwr(6'd31, 4'b0001, 32'h0);
        chk("R9", "fault on byte write", {31'd0, bus_fault}, 32'd1);
        mrd(6'd31, v); chk("R9", "byte write no program", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_relock();
        logic [31:0] v;
        do_reset();
        unlock();
        rwr(2'd1, 32'h1);
        rwr(2'd1, 32'h8);
        rrd(2'd2, v); chk("R10", "locked again", v, 32'h10);
        rrd(2'd1, v); chk("R10", "prog enable cleared", v, 32'h0);
        unlock();
        rrd(2'd2, v); chk("R10", "reopened by keys", v, 32'h0);
    endtask

    task automatic t_erase();
        logic [31:0] v;
        do_reset();
        unlock();
        rwr(2'd1, 32'h1);
        mwr(6'd7,  4'hF, 32'h0);
        mwr(6'd8,  4'hF, 32'h0);
        mwr(6'd15, 4'hF, 32'h0);
        mwr(6'd16, 4'hF, 32'h0);
        rwr(2'd1, (32'd1 << 8) | 32'h11);
        mrd(6'd8, v);  chk("R11", "page first word", v, 32'hFFFF_FFFF);
        mrd(6'd15, v); chk("R11", "page last word", v, 32'hFFFF_FFFF);
        mrd(6'd7, v);  chk("R11", "previous page kept", v, 32'h0);
        mrd(6'd16, v); chk("R11", "next page kept", v, 32'h0);
        rwr(2'd1, 32'h8);
        rwr(2'd1, (32'd2 << 8) | 32'h10);
        mrd(6'd16, v); chk("R11", "erase ignored when locked", v, 32'h0);
    endtask

    task automatic t_irq();
        do_reset();
        unlock();
        rwr(2'd1, 32'h2);
        mwr(6'd3, 4'hF, 32'h0);
        chk("R12", "irq before error visible", {31'd0, irq}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R12", "irq on error", {31'd0, irq}, 32'd1);
        rwr(2'd2, 32'h3);
        chk("R12", "irq after clear", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_unlock();
        t_wrong_key();
        t_ctrl_locked();
        t_locked_write();
        t_and_program();
        t_err_block();
        t_half_mode();
        t_relock();
        t_erase();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule